// File: doc/BRIEF.md
# Two-Bank Sub-Banked Filter Translation Buffer

This block is a small first-level address translation buffer placed in front of a larger main translation buffer. It converts 32-bit virtual addresses to physical page numbers for 4 KB pages. Its storage is split into two banks, and a lookup searches only the bank that one virtual-address bit selects, so the other bank stays idle. Each entry holds a single tag with two physical-page slots, so two neighbouring pages share one tag, and another address bit picks the slot.

A lookup is answered in the same cycle it is presented. When the filter misses, the surrounding logic gets the page from the main buffer or the miss handler and writes it back through the fill port. A fill that needs room replaces the least recently used entry of its bank. The replaced entry is not dropped: it appears on the victim port one cycle later, so the main buffer can keep it.

Top module: `ftlb_filter`

## Requirements
- R1: The address splits as follows: bits 31:14 are the tag, bit 13 selects the bank, bit 12 selects the slot inside an entry, and bits 11:0 (the page offset) do not affect any result.
- R2: A lookup with `lk_valid` high returns `lk_hit` and `lk_ppn` combinationally in the same cycle. It hits when an entry of the selected bank has a matching tag and a valid selected slot. `lk_hit` is never high without `lk_valid`.
- R3: A tag match where the selected slot is invalid counts as a miss.
- R4: An entry only answers lookups whose bank bit equals the bank it was filled into. At most one bank reports a hit.
- R5: A fill with a new tag writes the tag, the PPN into the addressed slot, and marks the other slot invalid. The page hits from the next cycle on.
- R6: A fill whose tag already matches a valid entry of its bank writes only the addressed slot of that entry. It evicts nothing and makes that entry most recently used. Tags stay unique within a bank.
- R7: Within a bank, every hit and every fill makes the touched entry most recently used. A fill of a new tag into a full bank replaces the least recently used entry. When a lookup and a fill touch the same bank in one cycle, the fill decides the recency update.
- R8: One cycle after a fill that replaces an entry, `vic_valid` is high for one cycle. The victim fields carry the old tag, its bank, both slot valid bits (bit 0 for slot 0) and both PPNs. `vic_valid` is never high except in the cycle after a fill.
- R9: A fill of a new tag uses an empty entry (lowest index first) when the bank has one, and then reports no victim.
- R10: Reset clears every valid bit. Afterwards every lookup misses and no victim is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_ppn | output | 20 | Physical page number on hit |
| fill_valid | input | 1 | Fill request |
| fill_vaddr | input | 32 | Virtual address of the filled page |
| fill_ppn | input | 20 | Physical page number of the filled page |
| vic_valid | output | 1 | Victim report strobe |
| vic_tag | output | 18 | Tag of the replaced entry |
| vic_bank | output | 1 | Bank of the replaced entry |
| vic_slot_vld | output | 2 | Slot valid bits of the replaced entry |
| vic_ppn0 | output | 20 | Slot 0 PPN of the replaced entry |
| vic_ppn1 | output | 20 | Slot 1 PPN of the replaced entry |

## Verification
A lookup result is due in the cycle the request is driven, so the monitor compares `lk_hit` and `lk_ppn` at the falling edge of that same cycle. A fill changes state at the next rising edge. Any victim it produces is registered at that edge, so the victim check is made at the falling edge one cycle after the fill was driven, and every later lookup sees the updated contents. The bench drives fills and lookups in separate cycles. It keeps its own model of each bank, with recency held as an ordered list, and a victim queue entry is popped for every fill so that a missing or extra strobe is caught.

// File: rtl/ftlb_pkg.sv
package ftlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_W     = 12;
  localparam int PPN_W    = 20;
  localparam int SLOT_BIT = PG_W;
  localparam int BANK_BIT = PG_W + 1;
  localparam int TAG_W    = VA_W - PG_W - 2;

  typedef logic [VA_W-1:0]  va_t;
  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [PPN_W-1:0] ppn_t;

  typedef struct packed {
    tag_t       tag;
    logic [1:0] vld;
    ppn_t       ppn1;
    ppn_t       ppn0;
  } line_t;

  function automatic tag_t va_tag(input va_t va);
    return va[VA_W-1:BANK_BIT+1];
  endfunction

  function automatic logic va_bank(input va_t va);
    return va[BANK_BIT];
  endfunction

  function automatic logic va_slot(input va_t va);
    return va[SLOT_BIT];
  endfunction
endpackage

// File: rtl/ftlb_lru.sv
module ftlb_lru #(
  parameter int WAYS = 4,
  localparam int IW = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] lru_idx
);
  logic [IW-1:0] age [WAYS];
  logic [WAYS-1:0] oldest_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (IW'(i) == touch_idx)            age[i] <= '0;
        else if (age[i] < age[touch_idx])   age[i] <= age[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_old
      assign oldest_vec[g] = (age[g] == IW'(WAYS - 1));
    end
  endgenerate

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < WAYS; i++)
      if (oldest_vec[i]) lru_idx = IW'(i);
  end

  assert_one_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
  assert_touched_not_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> lru_idx != $past(touch_idx));
endmodule

// File: rtl/ftlb_bank.sv
module ftlb_bank
  import ftlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int IW = $clog2(WAYS)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lk_en,
  input  tag_t  lk_tag,
  input  logic  lk_slot,
  output logic  lk_hit,
  output ppn_t  lk_ppn,
  input  logic  fl_en,
  input  tag_t  fl_tag,
  input  logic  fl_slot,
  input  ppn_t  fl_ppn,
  output logic  ev_valid,
  output line_t ev_line
);
  line_t ent [WAYS];

  logic [WAYS-1:0] lk_match, lk_hitv, fl_match, empty_vec;
  logic [IW-1:0]   hit_idx, merge_idx, empty_idx, lru_idx, alloc_idx, touch_idx;
  logic            fl_merge, has_empty, touch_en;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign empty_vec[g] = (ent[g].vld == 2'b00);
      assign lk_match[g]  = !empty_vec[g] && (ent[g].tag == lk_tag);
      assign lk_hitv[g]   = lk_match[g] && ent[g].vld[lk_slot];
      assign fl_match[g]  = !empty_vec[g] && (ent[g].tag == fl_tag);
    end
  endgenerate

  always_comb begin
    hit_idx   = '0;
    merge_idx = '0;
    empty_idx = '0;
    lk_ppn    = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (lk_hitv[i])   hit_idx   = IW'(i);
      if (fl_match[i])  merge_idx = IW'(i);
      if (empty_vec[i]) empty_idx = IW'(i);
    end
    for (int i = 0; i < WAYS; i++)
      if (lk_hitv[i]) lk_ppn = lk_slot ? ent[i].ppn1 : ent[i].ppn0;
  end

  assign lk_hit    = lk_en && (|lk_hitv);
  assign fl_merge  = |fl_match;
  assign has_empty = |empty_vec;
  assign alloc_idx = fl_merge ? merge_idx : (has_empty ? empty_idx : lru_idx);
  assign ev_valid  = fl_en && !fl_merge && !has_empty;
  assign ev_line   = ent[lru_idx];

  assign touch_en  = fl_en || lk_hit;
  assign touch_idx = fl_en ? alloc_idx : hit_idx;

  ftlb_lru #(.WAYS(WAYS)) i_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .lru_idx   (lru_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) ent[i] <= '0;
    end else if (fl_en) begin
      if (fl_merge) begin
        ent[alloc_idx].vld[fl_slot] <= 1'b1;
      end else begin
        ent[alloc_idx].tag <= fl_tag;
        ent[alloc_idx].vld <= fl_slot ? 2'b10 : 2'b01;
      end
      if (fl_slot) ent[alloc_idx].ppn1 <= fl_ppn;
      else         ent[alloc_idx].ppn0 <= fl_ppn;
    end
  end

  assert_unique_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_en |=> (ent[$past(alloc_idx)].tag == $past(fl_tag)) &&
              ent[$past(alloc_idx)].vld[$past(fl_slot)]);
  assert_merge_no_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && fl_merge) |-> !ev_valid);
endmodule

// File: rtl/ftlb_filter.sv
module ftlb_filter
  import ftlb_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_valid,
  input  logic [VA_W-1:0]  fill_vaddr,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             vic_valid,
  output logic [TAG_W-1:0] vic_tag,
  output logic             vic_bank,
  output logic [1:0]       vic_slot_vld,
  output logic [PPN_W-1:0] vic_ppn0,
  output logic [PPN_W-1:0] vic_ppn1
);
  logic [1:0] bank_hit, bank_ev;
  ppn_t       bank_ppn [2];
  line_t      bank_line [2];
  line_t      vic_q;
  logic       vic_b_q, vic_v_q;
  logic       fill_b;
  logic       unused_offset;

  assign unused_offset = ^{lk_vaddr[PG_W-1:0], fill_vaddr[PG_W-1:0]};
  assign fill_b = va_bank(fill_vaddr);

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      ftlb_bank #(.WAYS(WAYS)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_en    (lk_valid && (va_bank(lk_vaddr) == 1'(b))),
        .lk_tag   (va_tag(lk_vaddr)),
        .lk_slot  (va_slot(lk_vaddr)),
        .lk_hit   (bank_hit[b]),
        .lk_ppn   (bank_ppn[b]),
        .fl_en    (fill_valid && (fill_b == 1'(b))),
        .fl_tag   (va_tag(fill_vaddr)),
        .fl_slot  (va_slot(fill_vaddr)),
        .fl_ppn   (fill_ppn),
        .ev_valid (bank_ev[b]),
        .ev_line  (bank_line[b])
      );
    end
  endgenerate

  assign lk_hit = |bank_hit;
  assign lk_ppn = bank_hit[1] ? bank_ppn[1] : bank_ppn[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_v_q <= 1'b0;
      vic_b_q <= 1'b0;
      vic_q   <= '0;
    end else begin
      vic_v_q <= fill_valid && bank_ev[fill_b];
      if (fill_valid) begin
        vic_b_q <= fill_b;
        vic_q   <= bank_line[fill_b];
      end
    end
  end

  assign vic_valid    = vic_v_q;
  assign vic_tag      = vic_q.tag;
  assign vic_bank     = vic_b_q;
  assign vic_slot_vld = vic_q.vld;
  assign vic_ppn0     = vic_q.ppn0;
  assign vic_ppn1     = vic_q.ppn1;

  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);
  assert_single_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_vic_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> $past(fill_valid));
  assert_vic_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (vic_slot_vld != 2'b00));
endmodule

// File: tb/test_ftlb_filter.sv
`timescale 1ns/1ps
module test_ftlb_filter;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [19:0] fill_ppn = '0;
  logic        vic_valid;
  logic [17:0] vic_tag;
  logic        vic_bank;
  logic [1:0]  vic_slot_vld;
  logic [19:0] vic_ppn0, vic_ppn1;

  always #10 clk = ~clk;

  ftlb_filter #(.WAYS(WAYS)) i_ftlb_filter (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn),
    .vic_valid(vic_valid), .vic_tag(vic_tag), .vic_bank(vic_bank),
    .vic_slot_vld(vic_slot_vld), .vic_ppn0(vic_ppn0), .vic_ppn1(vic_ppn1)
  );

  typedef struct { bit hit; logic [19:0] ppn; string req; } lk_exp_t;
  typedef struct { bit v; logic [17:0] tag; bit bank; logic [1:0] vld;
                   logic [19:0] p0; logic [19:0] p1; string req; } vic_exp_t;

  lk_exp_t  lk_q[$];
  vic_exp_t vic_q[$];
  int checks = 0, fails = 0;

  // Reference model: recency kept as an ordered list, LRU at the front.
  logic [17:0] m_tag [2][WAYS];
  bit          m_v   [2][WAYS][2];
  logic [19:0] m_ppn [2][WAYS][2];
  int          m_ord [2][$];

  function automatic logic [31:0] mk(input logic [17:0] t, input bit b,
                                     input bit s, input logic [11:0] off);
    return {t, b, s, off};   // R1 field placement
  endfunction

  function automatic void touch(input int b, input int e);
    foreach (m_ord[b][k]) if (m_ord[b][k] == e) begin m_ord[b].delete(k); break; end
    m_ord[b].push_back(e);
  endfunction

  function automatic int find(input int b, input logic [17:0] t);
    for (int e = 0; e < WAYS; e++)
      if ((m_v[b][e][0] || m_v[b][e][1]) && m_tag[b][e] == t) return e;
    return -1;
  endfunction

  task automatic lookup(input logic [31:0] va, input string req);
    lk_exp_t x;
    int b = va[13], s = va[12], e;
    e = find(b, va[31:14]);
    x.hit = (e >= 0) && m_v[b][e][s];
    x.ppn = x.hit ? m_ppn[b][e][s] : '0;
    x.req = req;
    @(posedge clk); #1;
    fill_valid = 1'b0; lk_valid = 1'b1; lk_vaddr = va;
    lk_q.push_back(x);
    if (x.hit) touch(b, e);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] p, input string req);
    vic_exp_t x;
    int b = va[13], s = va[12], e;
    x.v = 0; x.tag = '0; x.bank = 0; x.vld = '0; x.p0 = '0; x.p1 = '0; x.req = req;
    e = find(b, va[31:14]);
    if (e < 0) begin
      for (int k = WAYS - 1; k >= 0; k--)
        if (!m_v[b][k][0] && !m_v[b][k][1]) e = k;
      if (e < 0) begin
        e = m_ord[b][0];
        x.v = 1; x.tag = m_tag[b][e]; x.bank = bit'(b);
        x.vld = {m_v[b][e][1], m_v[b][e][0]};
        x.p0 = m_ppn[b][e][0]; x.p1 = m_ppn[b][e][1];
      end
      m_tag[b][e] = va[31:14];
      m_v[b][e][0] = 0; m_v[b][e][1] = 0;
    end
    m_v[b][e][s] = 1; m_ppn[b][e][s] = p;
    touch(b, e);
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b1; fill_vaddr = va; fill_ppn = p;
    vic_q.push_back(x);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b0;
  endtask

  // Monitor
  bit vic_pend = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_valid) begin
        lk_exp_t x;
        checks++;
        if (lk_q.size() == 0) begin
          fails++; $display("FAIL lookup: no expectation queued");
        end else begin
          x = lk_q.pop_front();
          if (lk_hit !== x.hit || (x.hit && lk_ppn !== x.ppn)) begin
            fails++;
            $display("FAIL %s: lookup %h hit=%0b ppn=%h expected hit=%0b ppn=%h",
                     x.req, lk_vaddr, lk_hit, lk_ppn, x.hit, x.ppn);
          end
        end
      end
      if (vic_pend) begin
        vic_exp_t y;
        checks++;
        y = vic_q.pop_front();
        if (vic_valid !== y.v ||
            (y.v && (vic_tag !== y.tag || vic_bank !== y.bank || vic_slot_vld !== y.vld ||
                     (y.vld[0] && vic_ppn0 !== y.p0) || (y.vld[1] && vic_ppn1 !== y.p1)))) begin
          fails++;
          $display("FAIL %s: victim v=%0b tag=%h bank=%0b vld=%b p0=%h p1=%h expected v=%0b tag=%h bank=%0b vld=%b p0=%h p1=%h",
                   y.req, vic_valid, vic_tag, vic_bank, vic_slot_vld, vic_ppn0, vic_ppn1,
                   y.v, y.tag, y.bank, y.vld, y.p0, y.p1);
        end
      end else if (vic_valid) begin
        checks++; fails++;
        $display("FAIL R8: victim strobe without preceding fill, got 1 expected 0");
      end
      vic_pend = fill_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int e = WAYS - 1; e >= 0; e--) m_ord[b].push_back(e);
      for (int e = 0; e < WAYS; e++) begin
        m_tag[b][e] = '0; m_v[b][e][0] = 0; m_v[b][e][1] = 0;
        m_ppn[b][e][0] = '0; m_ppn[b][e][1] = '0;
      end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    checks++;
    if (vic_valid !== 1'b0) begin
      fails++; $display("FAIL R10: vic_valid=%0b expected 0 after reset", vic_valid);
    end
    // R10: everything misses after reset
    lookup(mk(18'h0, 0, 0, 12'h0), "R10");
    lookup(mk(18'h3ffff, 1, 1, 12'hfff), "R10");
    // R5 / R2 / R3 / R4 / R1
    fill(mk(18'h00a11, 0, 0, 12'h123), 20'hA0001, "R9");
    lookup(mk(18'h00a11, 0, 0, 12'h000), "R5");
    lookup(mk(18'h00a11, 0, 0, 12'hfff), "R1");
    lookup(mk(18'h00a11, 0, 1, 12'h000), "R3");
    lookup(mk(18'h00a11, 1, 0, 12'h000), "R4");
    // R6: merge into existing tag, no victim
    fill(mk(18'h00a11, 0, 1, 12'h000), 20'hA0002, "R6");
    lookup(mk(18'h00a11, 0, 1, 12'h456), "R6");
    lookup(mk(18'h00a11, 0, 0, 12'h000), "R2");
    // R9: fill remaining empty entries, no victims
    fill(mk(18'h00b22, 0, 0, 12'h0), 20'hB0000, "R9");
    fill(mk(18'h00c33, 0, 1, 12'h0), 20'hC0001, "R9");
    fill(mk(18'h00d44, 0, 0, 12'h0), 20'hD0000, "R9");
    // R7: touch oldest-filled entry, then force eviction of next oldest
    lookup(mk(18'h00a11, 0, 0, 12'h0), "R7");
    fill(mk(18'h00e55, 0, 0, 12'h0), 20'hE0000, "R8");
    lookup(mk(18'h00b22, 0, 0, 12'h0), "R7");
    lookup(mk(18'h00a11, 0, 1, 12'h0), "R7");
    // R6 merge marks MRU: merge c33 then evict -> d44 goes
    fill(mk(18'h00c33, 0, 0, 12'h0), 20'hC0000, "R6");
    fill(mk(18'h00f66, 0, 1, 12'h0), 20'hF0001, "R8");
    lookup(mk(18'h00d44, 0, 0, 12'h0), "R7");
    // Bank 1 independently, including eviction of a two-slot entry
    for (int i = 0; i < 5; i++) begin
      fill(mk(18'h01000 + 18'(i), 1, 0, 12'h0), 20'h10000 + 20'(i), "R8");
      if (i == 0) fill(mk(18'h01000, 1, 1, 12'h0), 20'h1FFFF, "R6");
    end
    lookup(mk(18'h01000, 1, 1, 12'h0), "R7");
    idle();
    // Random mix over a small tag set
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] va = mk(18'h02000 + 18'(r[2:0] % 7), r[3], r[4], r[16:5]);
      if (r[20:18] < 3'd3) fill(va, 20'(r[31:12] ^ 20'h5A5A5), "R7");
      else                 lookup(va, "R2");
    end
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule